// File: doc/BRIEF.md
# Indexed Mask Interrupt Controller

This unit collects 64 level-sensitive interrupt request lines and reports to the processor which one should be serviced. Each line has a mask bit and a small control byte that holds its priority level. On every clock the unit looks at all requests that are both asserted and unmasked and have a level above zero. It picks the one with the highest level, and on a tie the lowest-numbered line wins. It then registers that level and line number on its outputs.

Software never rewrites the whole mask. It writes a line number to a "mask one" register or to an "unmask one" register, and only that line's bit changes, so no read-modify-write is needed. The value 0xFF acts on all 64 bits at once. Any other value of 64 or more is ignored. The control bytes sit at addresses 0 to 63, one per line. The mask registers sit above them at 64 and 65. A write to any other address changes nothing.

Top module: `irqc_top`

## Requirements
- R1: After reset all 64 mask bits are 1, every level is 0, and both outputs read 0.
- R2: A write of n (0..63) to address 64 (mask one) sets mask bit n and no other bit.
- R3: A write of n (0..63) to address 65 (unmask one) clears mask bit n and no other bit.
- R4: A write of 0xFF to address 64 sets all 64 mask bits.
- R5: A write of 0xFF to address 65 clears all 64 mask bits.
- R6: A write of a value from 64 to 254 to address 64 or 65 leaves every mask bit unchanged.
- R7: A write to address n (0..63) stores bits [2:0] of the data as the level of line n; bits [7:3] are discarded. A line whose level is 0 never wins.
- R8: Requests are level-sensitive: a line is a candidate in every cycle its input is 1, and stops being one as soon as the input falls.
- R9: Among candidates (input 1, mask bit 0, level not 0) the highest level is reported.
- R10: Among candidates that share the highest level, the lowest line number is reported.
- R11: Both outputs are registered. A change of request or state is visible after exactly one clock edge. When no candidate exists, the level output and the line output are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 7 | Write address: 0..63 control bytes, 64 mask one, 65 unmask one |
| wr_data | input | 8 | Write data byte |
| irq_req | input | 64 | Level-sensitive request lines |
| irq_level | output | 3 | Level of the winning line, 0 when none |
| irq_src | output | 6 | Number of the winning line, 0 when none |

## Verification
The checker watches the mask register on every cycle. It confirms the single-bit set and clear writes, the 0xFF writes that act on all bits, and that out-of-range values leave the mask unchanged. It also checks that any reported winner was requesting and unmasked one cycle earlier, and that an idle level output always comes with line 0. Whether the winner is really the highest level with the lowest number on ties, and that the upper data bits are discarded, can only be shown by the bench. It sweeps every line, every mask index and every out-of-range value against an arithmetic model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NSRC     = 64;
    localparam int SRC_W    = $clog2(NSRC);
    localparam int LVL_W    = 3;
    localparam int ADDR_W   = SRC_W + 1;
    localparam logic [ADDR_W-1:0] ADDR_SET = ADDR_W'(NSRC);
    localparam logic [ADDR_W-1:0] ADDR_CLR = ADDR_W'(NSRC + 1);
    localparam logic [7:0] IDX_ALL = 8'hFF;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic [SRC_W-1:0] src;
    } irq_win_t;

    typedef enum logic [1:0] {
        MOP_NONE = 2'd0,
        MOP_SET  = 2'd1,
        MOP_CLR  = 2'd2
    } mask_op_e;

    function automatic logic idx_hits(input logic [7:0] data, input int unsigned bit_n);
        return (data == IDX_ALL) || (data == 8'(bit_n));
    endfunction
endpackage

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  mask_op_e        op,
    input  logic [7:0]      idx,
    output logic [NSRC-1:0] mask
);
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                mask[i] <= 1'b1;
            end else if (idx_hits(idx, i)) begin
                if (op == MOP_SET) begin
                    mask[i] <= 1'b1;
                end else if (op == MOP_CLR) begin
                    mask[i] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/irqc_level_bank.sv
module irqc_level_bank
    import irqc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [7:0]                wr_data,
    output logic [NSRC-1:0][LVL_W-1:0] levels
);
    for (genvar i = 0; i < NSRC; i++) begin : g_ctl
        always_ff @(posedge clk) begin
            if (rst) begin
                levels[i] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(i)) begin
                levels[i] <= wr_data[LVL_W-1:0];
            end
        end
    end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
(
    input  logic [NSRC-1:0]            req,
    input  logic [NSRC-1:0]            mask,
    input  logic [NSRC-1:0][LVL_W-1:0] levels,
    output irq_win_t                   win
);
    logic [NSRC-1:0][LVL_W-1:0] eff;

    for (genvar i = 0; i < NSRC; i++) begin : g_eff
        assign eff[i] = (req[i] && !mask[i]) ? levels[i] : '0;
    end

    always_comb begin
        win = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (eff[i] != '0 && eff[i] >= win.level) begin
                win.level = eff[i];
                win.src   = SRC_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [6:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [63:0]      irq_req,
    output logic [2:0]       irq_level,
    output logic [5:0]       irq_src
);
    mask_op_e                   mop;
    logic [NSRC-1:0]            mask_q;
    logic [NSRC-1:0][LVL_W-1:0] lvl_q;
    irq_win_t                   win_d;
    irq_win_t                   win_q;

    always_comb begin
        mop = MOP_NONE;
        if (wr_en && wr_addr == ADDR_SET) begin
            mop = MOP_SET;
        end else if (wr_en && wr_addr == ADDR_CLR) begin
            mop = MOP_CLR;
        end
    end

    irqc_mask_bank u_mask (
        .clk  (clk),
        .rst  (rst),
        .op   (mop),
        .idx  (wr_data),
        .mask (mask_q)
    );

    irqc_level_bank u_lvl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .levels  (lvl_q)
    );

    irqc_arbiter u_arb (
        .req    (irq_req),
        .mask   (mask_q),
        .levels (lvl_q),
        .win    (win_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign irq_level = win_q.level;
    assign irq_src   = win_q.src;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [6:0]       wr_addr,
    input logic [7:0]       wr_data,
    input logic [63:0]      irq_req,
    input logic [2:0]       irq_level,
    input logic [5:0]       irq_src,
    input logic [63:0]      mask
);
    logic [63:0] req_q;
    logic [63:0] mask_prev;
    logic [5:0]  idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q     <= '0;
            mask_prev <= '1;
            idx_q     <= '0;
        end else begin
            req_q     <= irq_req;
            mask_prev <= mask;
            idx_q     <= wr_data[5:0];
        end
    end

    p_set_one_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_SET && wr_data < 8'd64) |=> mask[idx_q]);

    p_set_only_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_SET && wr_data < 8'd64)
        |=> ((mask & ~(64'd1 << idx_q)) == (mask_prev & ~(64'd1 << idx_q))));

    p_clr_one_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_CLR && wr_data < 8'd64) |=> !mask[idx_q]);

    p_all_set_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_SET && wr_data == 8'hFF) |=> (mask == '1));

    p_all_clr_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_CLR && wr_data == 8'hFF) |=> (mask == '0));

    p_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == ADDR_SET || wr_addr == ADDR_CLR)
         && wr_data >= 8'd64 && wr_data != 8'hFF) |=> $stable(mask));

    p_winner_live_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_level != 3'd0) |-> (req_q[irq_src] && !mask_prev[irq_src]));

    p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (irq_level == 3'd0) |-> (irq_src == 6'd0));
endmodule

bind irqc_top irqc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .irq_req   (irq_req),
    .irq_level (irq_level),
    .irq_src   (irq_src),
    .mask      (mask_q)
);

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [63:0] irq_req = '0;
    logic [2:0]  irq_level;
    logic [5:0]  irq_src;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [63:0] m_mask;
    logic [2:0]  m_lvl [64];

    always #2.5 clk = ~clk;

    irqc_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq_req(irq_req),
        .irq_level(irq_level), .irq_src(irq_src)
    );

    function automatic logic [8:0] model();
        logic [2:0] bl = 3'd0;
        logic [5:0] bs = 6'd0;
        for (int i = 63; i >= 0; i--) begin
            if (irq_req[i] && !m_mask[i] && m_lvl[i] != 3'd0 && m_lvl[i] >= bl) begin
                bl = m_lvl[i];
                bs = 6'(i);
            end
        end
        return {bl, bs};
    endfunction

    task automatic cmp(input string tag, input logic [2:0] el, input logic [5:0] es);
        n_checks++;
        if (irq_level !== el || irq_src !== es) begin
            n_fail++;
            $display("FAIL %s: got level=%0d src=%0d, expected level=%0d src=%0d",
                     tag, irq_level, irq_src, el, es);
        end
    endtask

    task automatic settle_check(input string tag);
        logic [8:0] e;
        repeat (2) @(posedge clk);
        @(negedge clk);
        e = model();
        cmp(tag, e[8:6], e[5:0]);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 7'd64) m_lvl[a] = d[2:0];
        else if (a == 7'd64) begin
            if (d == 8'hFF) m_mask = '1;
            else if (d < 8'd64) m_mask[d[5:0]] = 1'b1;
        end else if (a == 7'd65) begin
            if (d == 8'hFF) m_mask = '0;
            else if (d < 8'd64) m_mask[d[5:0]] = 1'b0;
        end
    endtask

    initial begin
        m_mask = '1;
        for (int i = 0; i < 64; i++) m_lvl[i] = 3'd0;
        irq_req = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        settle_check("R1 reset masked");
        cmp("R1 reset outputs", 3'd0, 6'd0);
        wr(7'd65, 8'hFF);
        settle_check("R1 reset levels zero (R7)");

        // R7: program levels with junk in upper bits
        for (int i = 0; i < 64; i++) wr(7'(i), 8'(((i * 3) % 7) + 1) | 8'hA8);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            irq_req = 64'd1 << i;
            settle_check("R7 single line level");
        end

        // R11: one-edge latency after request change
        @(negedge clk);
        irq_req = 64'd1 << 10;
        repeat (2) @(posedge clk);
        @(negedge clk);
        irq_req = 64'd1 << 20;
        @(posedge clk);
        @(negedge clk);
        cmp("R11 one edge latency", m_lvl[20], 6'd20);
        // R8: release
        irq_req = '0;
        @(posedge clk);
        @(negedge clk);
        cmp("R8 release drops", 3'd0, 6'd0);

        // R2/R10: equal levels, mask lines one by one
        for (int i = 0; i < 64; i++) wr(7'(i), 8'd4);
        @(negedge clk);
        irq_req = '1;
        wr(7'd65, 8'hFF);
        settle_check("R5 all unmasked");
        for (int i = 0; i < 64; i++) begin
            wr(7'd64, 8'(i));
            settle_check("R2 set one / R10 lowest wins");
        end
        // R3: unmask from top down
        for (int i = 63; i >= 0; i--) begin
            wr(7'd65, 8'(i));
            settle_check("R3 clear one / R10");
        end
        // R6: out-of-range values change nothing
        wr(7'd64, 8'd5);
        for (int v = 64; v < 255; v++) begin
            wr(7'd64, 8'(v));
            wr(7'd65, 8'(v));
        end
        settle_check("R6 ignored values");
        cmp("R6 ignored values ports", 3'd4, 6'd0);
        wr(7'd64, 8'hFF);
        settle_check("R4 all masked");

        // R9/R10 mixed patterns with random writes
        for (int i = 0; i < 64; i++) wr(7'(i), 8'((i * 5 + 3) % 8));
        wr(7'd65, 8'hFF);
        for (int k = 0; k < 400; k++) begin
            int unsigned r = $urandom;
            @(negedge clk);
            irq_req = {$urandom, $urandom} & {$urandom, $urandom};
            case (r % 6)
                0: wr(7'd64, 8'(r >> 8) & 8'h3F);
                1: wr(7'd65, 8'(r >> 8) & 8'h3F);
                2: wr(7'((r >> 8) % 64), 8'(r >> 16));
                3: wr(7'(64 + ((r >> 8) % 2)), ((r >> 12) % 4 == 0) ? 8'hFF : 8'(r >> 16));
                default: ;
            endcase
            settle_check("R9 highest level / R10 tie");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule